// File: doc/BRIEF.md
# Immediate Operand Word Assembler

This block builds an immediate operand out of the 16-bit words that follow an instruction in the instruction stream. A caller starts an operation by giving the operand length in bytes (1, 2, 4, 8 or 12). The block then takes the needed number of words through a valid/ready input and packs them into up to three 32-bit lanes. A one-cycle done pulse reports the 96-bit result and the number of stream bytes used.

Short operands are widened to 32 bits with their sign. A byte operand still uses a whole stream word and takes its value from the low byte of that word. Longer operands are packed high-word-first, two words per lane, starting at lane 0. A fetch fault flagged with any word stops the operation. An unsupported length is refused at once and consumes no words. Whether the operand is later read as an integer or as a floating-point value is the user's concern.

Top module: `imm_operand_assembler`

## Requirements
- R1: After reset, `done`, `fault`, `size_err` and `word_ready` are 0, and `result` and `bytes_used` are 0.
- R2: A `start` taken while idle with a legal length makes `word_ready` high until exactly N words are taken: N is 1, 1, 2, 4 or 6 for lengths 1, 2, 4, 8 or 12. On success `bytes_used` reports 2*N.
- R3: For length 1, lane 0 (`result[31:0]`) is bits 7:0 of the word, sign-extended from bit 7. Bits 15:8 of the word have no effect.
- R4: For length 2, lane 0 is the word sign-extended from bit 15.
- R5: For lengths 4, 8 and 12, lane 0 holds the first word in bits 31:16 and the second word in bits 15:0.
- R6: Lane 1 (`result[63:32]`) holds words 3 and 4, high half first, for lengths 8 and 12. Lane 2 (`result[95:64]`) holds words 5 and 6 for length 12.
- R7: Lanes that the length does not fill read as 0.
- R8: `done` is high for exactly one cycle, in the cycle after the final word is taken. `result` keeps its value until the next accepted `start`, which clears it.
- R9: A word taken with `word_fault` high ends the operation. `done` and `fault` are then high together, `result` is 0, and `bytes_used` is 2 times the number of words taken before the faulting one.
- R10: Any length other than 1, 2, 4, 8 or 12 gives `done` with `size_err` in the cycle after `start`. `bytes_used` and `result` are then 0, and `word_ready` stays low.
- R11: A `start` during an operation is ignored. A word offered while idle is not taken (`word_ready` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op_size | input | 4 | Operand length in bytes |
| word_valid | input | 1 | Stream word offered |
| word_data | input | 16 | Stream word |
| word_fault | input | 1 | Fetch of the offered word faulted |
| word_ready | output | 1 | Block takes the offered word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation ended by a fetch fault (valid with done) |
| size_err | output | 1 | Unsupported length (valid with done) |
| bytes_used | output | 4 | Stream bytes consumed |
| result | output | 96 | Three 32-bit lanes, lane 0 in the low bits |

## Verification
A `start` is taken on the clock edge where it is high, so a length error shows on `done` one cycle later. The final word, or a faulting word, is taken on an edge with `word_valid` high, and `done`, `result` and `bytes_used` change on that same edge. The bench changes inputs and samples outputs on falling edges. It therefore checks each result at the first falling edge after the edge that takes the word, and at the next falling edge it checks that `done` has dropped and `result` is unchanged. Random gaps in `word_valid` shift when the final word arrives, and the bench adjusts for this by counting the edges itself.

// File: rtl/imm_asm_pkg.sv
package imm_asm_pkg;

  localparam int WORD_W = 16;
  localparam int LANE_W = 32;

  typedef enum logic [0:0] {
    SEQ_IDLE    = 1'b0,
    SEQ_COLLECT = 1'b1
  } seq_state_e;

  // widen the low byte of a stream word, keeping its sign
  function automatic logic [LANE_W-1:0] widen_low_byte(input logic [WORD_W-1:0] w);
    return {{(LANE_W-8){w[7]}}, w[7:0]};
  endfunction

  // widen a whole stream word, keeping its sign
  function automatic logic [LANE_W-1:0] widen_half(input logic [WORD_W-1:0] w);
    return {{(LANE_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  // first word lands in the upper half of a lane
  function automatic logic [LANE_W-1:0] join_words(input logic [WORD_W-1:0] hi,
                                                   input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  // stream words needed for a length; 0 marks an unsupported length
  function automatic int unsigned words_for_size(input int unsigned sz,
                                                 input int unsigned lanes);
    if (sz == 1 || sz == 2) return 1;
    if (sz != 0 && (sz % 4) == 0 && sz <= 4 * lanes) return sz / 2;
    return 0;
  endfunction

endpackage

// File: rtl/imm_size_decode.sv
module imm_size_decode
  import imm_asm_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SZ_W  = 4,
  parameter int CNT_W = 3
) (
  input  logic [SZ_W-1:0]  size,
  output logic             legal,
  output logic [CNT_W-1:0] words
);

  int unsigned n_words;

  always_comb begin
    n_words = words_for_size(32'(size), LANES);
    words   = CNT_W'(n_words);
    legal   = (n_words != 0);
  end

endmodule

// File: rtl/imm_seq_ctrl.sv
module imm_seq_ctrl
  import imm_asm_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  logic [CNT_W-1:0] need,
  input  logic             word_valid,
  input  logic             word_fault,
  output seq_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             word_ready,
  output logic             start_acc,
  output logic             word_acc,
  output logic             finish_evt,
  output logic             fault_evt,
  output logic             err_evt
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need_q;

  assign state      = state_q;
  assign cnt        = cnt_q;
  assign word_ready = (state_q == SEQ_COLLECT);
  assign start_acc  = start && (state_q == SEQ_IDLE);
  assign word_acc   = word_valid && word_ready;
  assign fault_evt  = word_acc && word_fault;
  assign finish_evt = word_acc && !word_fault && ((cnt_q + CNT_W'(1)) == need_q);
  assign err_evt    = start_acc && !legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      need_q  <= '0;
    end else if (start_acc && legal) begin
      state_q <= SEQ_COLLECT;
      cnt_q   <= '0;
      need_q  <= need;
    end else if (fault_evt || finish_evt) begin
      state_q <= SEQ_IDLE;
    end else if (word_acc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BELOW_NEED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_COLLECT) |-> (cnt_q < need_q)); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_COLLECT && !finish_evt && !fault_evt)
      |=> (state_q == SEQ_COLLECT) && $stable(need_q)); // R11

endmodule

// File: rtl/imm_lane_pack.sv
module imm_lane_pack
  import imm_asm_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SZ_W  = 4,
  parameter int CNT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [CNT_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [SZ_W-1:0]          size,
  output logic [LANES*LANE_W-1:0]  lanes
);

  localparam int MAXW = 2 * LANES;

  logic [WORD_W-1:0] words_q [MAXW];
  logic [WORD_W-1:0] words_n [MAXW];

  // buffer as it will be once the incoming word is written
  always_comb begin
    for (int i = 0; i < MAXW; i++) begin
      words_n[i] = (wr_en && wr_idx == CNT_W'(i)) ? wr_data : words_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < MAXW; i++) words_q[i] <= '0;
    end else if (wr_en) begin
      words_q[wr_idx] <= wr_data;
    end
  end

  // lane 0 depends on the length; the others are either filled or zero
  always_comb begin
    if (size == SZ_W'(1))      lanes[LANE_W-1:0] = widen_low_byte(words_n[0]);
    else if (size == SZ_W'(2)) lanes[LANE_W-1:0] = widen_half(words_n[0]);
    else                       lanes[LANE_W-1:0] = join_words(words_n[0], words_n[1]);
  end

  for (genvar k = 1; k < LANES; k++) begin : g_lane
    assign lanes[k*LANE_W +: LANE_W] = (32'(size) > 32'(4 * k))
                                       ? join_words(words_n[2*k], words_n[2*k+1])
                                       : '0;
  end

endmodule

// File: rtl/imm_operand_assembler.sv
module imm_operand_assembler
  import imm_asm_pkg::*;
#(
  parameter  int LANES = 3,
  localparam int SZ_W  = $clog2(4 * LANES + 1),
  localparam int CNT_W = $clog2(2 * LANES + 1),
  localparam int RES_W = LANES * 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SZ_W-1:0]  op_size,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  input  logic             word_fault,
  output logic             word_ready,
  output logic             done,
  output logic             fault,
  output logic             size_err,
  output logic [SZ_W-1:0]  bytes_used,
  output logic [RES_W-1:0] result
);

  logic             size_legal;
  logic [CNT_W-1:0] size_words;
  seq_state_e       seq_state;
  logic [CNT_W-1:0] word_cnt;
  logic             start_acc, word_acc, finish_evt, fault_evt, err_evt;
  logic [SZ_W-1:0]  size_q;
  logic [RES_W-1:0] lanes_nxt;
  logic [CNT_W-1:0] need_q;

  logic             done_q, fault_q, err_q;
  logic [SZ_W-1:0]  bytes_q;
  logic [RES_W-1:0] result_q;

  imm_size_decode #(.LANES(LANES), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_dec (
    .size  (op_size),
    .legal (size_legal),
    .words (size_words)
  );

  imm_seq_ctrl #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .legal      (size_legal),
    .need       (size_words),
    .word_valid (word_valid),
    .word_fault (word_fault),
    .state      (seq_state),
    .cnt        (word_cnt),
    .word_ready (word_ready),
    .start_acc  (start_acc),
    .word_acc   (word_acc),
    .finish_evt (finish_evt),
    .fault_evt  (fault_evt),
    .err_evt    (err_evt)
  );

  imm_lane_pack #(.LANES(LANES), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_acc),
    .wr_en   (word_acc && !word_fault),
    .wr_idx  (word_cnt),
    .wr_data (word_data),
    .size    (size_q),
    .lanes   (lanes_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      need_q <= '0;
    end else if (start_acc) begin
      size_q <= op_size;
      need_q <= size_words;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      err_q    <= 1'b0;
      bytes_q  <= '0;
      result_q <= '0;
    end else begin
      done_q  <= finish_evt || fault_evt || err_evt;
      fault_q <= fault_evt;
      err_q   <= err_evt;
      if (start_acc) begin
        bytes_q  <= '0;
        result_q <= '0;
      end else if (finish_evt) begin
        bytes_q  <= SZ_W'({need_q, 1'b0});
        result_q <= lanes_nxt;
      end else if (fault_evt) begin
        bytes_q  <= SZ_W'({word_cnt, 1'b0});
        result_q <= '0;
      end
    end
  end

  assign done       = done_q;
  assign fault      = fault_q;
  assign size_err   = err_q;
  assign bytes_used = bytes_q;
  assign result     = result_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !finish_evt && !fault_evt) |=> $stable(result)); // R8

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && !size_err && result == '0)); // R9

  AST_ERR_NOTHING_USED: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (done && bytes_used == '0 && result == '0 && !word_ready)); // R10

  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_IDLE) |-> !word_ready); // R11

  AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && !size_err && 32'(size_q) <= 32'd4)
      |-> (result[RES_W-1:32] == '0)); // R7

endmodule

// File: tb/sim_imm_operand_assembler.sv
module sim_imm_operand_assembler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_size = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_fault = 1'b0;
  logic        word_ready, done, fault, size_err;
  logic [3:0]  bytes_used;
  logic [95:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  imm_operand_assembler u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
    .word_valid(word_valid), .word_data(word_data), .word_fault(word_fault),
    .word_ready(word_ready), .done(done), .fault(fault), .size_err(size_err),
    .bytes_used(bytes_used), .result(result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_words(input int sz);
    case (sz)
      1, 2: return 1;
      4:    return 2;
      8:    return 4;
      12:   return 6;
      default: return 0;
    endcase
  endfunction

  // bench model: build lanes by shifting, sign handling by arithmetic
  function automatic logic [95:0] exp_result(input int sz, input logic [15:0] w [6]);
    logic [95:0] r = '0;
    int v;
    if (sz == 1) begin
      v = int'(w[0] & 16'h00ff);
      if (v >= 128) v = v - 256;
      r[31:0] = 32'(v);
    end else if (sz == 2) begin
      v = int'(w[0]);
      if (v >= 32768) v = v - 65536;
      r[31:0] = 32'(v);
    end else begin
      for (int i = 0; i < sz / 2; i++) begin
        logic [31:0] ln;
        ln = r[(i/2)*32 +: 32];
        ln = (ln << 16) | 32'(w[i]);
        r[(i/2)*32 +: 32] = ln;
      end
    end
    return r;
  endfunction

  // one operation; fault_at < 0 means no fault
  task automatic run_op(input int sz, input logic [15:0] w [6], input int fault_at,
                        input bit gaps, input string tag);
    int n = exp_words(sz);
    logic [95:0] exp_r;
    @(negedge clk);
    start = 1'b1; op_size = 4'(sz);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done && size_err && !fault, "R10 error done", {93'd0, done, size_err, fault}, 96'd6);
      chk(bytes_used == 0 && result == 0, "R10 nothing used", result, 96'd0);
      chk(!word_ready, "R10 no ready", 96'(word_ready), 96'd0);
      @(negedge clk);
      chk(!done && !word_ready, "R10 pulse ends", 96'(done), 96'd0);
      return;
    end
    chk(word_ready && result == 0, {tag, " R2 ready, R8 cleared"}, result, 96'd0);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int g = int'($urandom_range(0, 2));
        for (int j = 0; j < g; j++) begin
          word_valid = 1'b0;
          @(negedge clk);
        end
      end
      word_valid = 1'b1; word_data = w[i]; word_fault = (i == fault_at);
      @(negedge clk);
      word_valid = 1'b0; word_fault = 1'b0;
      if (i == fault_at) begin
        chk(done && fault && !size_err, {tag, " R9 fault done"}, {94'd0, done, fault}, 96'd3);
        chk(result == 0 && bytes_used == 4'(2 * i), {tag, " R9 bytes/result"},
            {result[91:0], bytes_used}, {92'd0, 4'(2 * i)});
        chk(!word_ready, {tag, " R9 stops"}, 96'(word_ready), 96'd0);
        @(negedge clk);
        chk(!done, {tag, " R8 pulse"}, 96'(done), 96'd0);
        return;
      end
      if (i < n - 1) chk(!done && word_ready, {tag, " R2 still collecting"},
                         {94'd0, done, word_ready}, 96'd1);
    end
    exp_r = exp_result(sz, w);
    chk(done && !fault && !size_err, {tag, " R8 done"}, {93'd0, done, fault, size_err}, 96'd4);
    chk(result == exp_r, {tag, " R3 R4 R5 R6 R7 result"}, result, exp_r);
    chk(bytes_used == 4'(2 * n), {tag, " R2 bytes"}, 96'(bytes_used), 96'(2 * n));
    chk(!word_ready, {tag, " R2 exactly N words"}, 96'(word_ready), 96'd0);
    @(negedge clk);
    chk(!done && result == exp_r, {tag, " R8 pulse and hold"}, result, exp_r);
  endtask

  initial begin
    logic [15:0] w [6];
    int sizes [5] = '{1, 2, 4, 8, 12};
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(!done && !fault && !size_err && !word_ready, "R1 flags", {92'd0, done, fault, size_err, word_ready}, 96'd0);
    chk(result == 0 && bytes_used == 0, "R1 data", result, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_ready && !done, "R1 after release", 96'(word_ready), 96'd0);

    // R3: negative byte, upper byte ignored
    w = '{16'h1280, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    run_op(1, w, -1, 0, "R3 neg byte");
    w[0] = 16'hFF7F;
    run_op(1, w, -1, 0, "R3 pos byte");
    // R4
    w[0] = 16'h8000;
    run_op(2, w, -1, 0, "R4 neg word");
    w[0] = 16'h7FFF;
    run_op(2, w, -1, 0, "R4 pos word");
    // R5 R6 R7
    w = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718, 16'h293A, 16'h4B5C};
    run_op(4, w, -1, 0, "R5 long");
    run_op(8, w, -1, 1, "R6 double");
    run_op(12, w, -1, 1, "R6 triple");
    // R9 fault at first and last word
    run_op(12, w, 0, 0, "R9 first");
    run_op(12, w, 5, 1, "R9 last");
    run_op(8, w, 2, 0, "R9 mid");
    // R10
    run_op(0, w, -1, 0, "R10 zero");
    run_op(3, w, -1, 0, "R10 three");
    run_op(13, w, -1, 0, "R10 thirteen");
    run_op(15, w, -1, 0, "R10 fifteen");

    // R11: words offered while idle are not taken
    @(negedge clk);
    word_valid = 1'b1; word_data = 16'hDEAD;
    repeat (3) begin
      @(negedge clk);
      chk(!word_ready && !done, "R11 idle word ignored", 96'(word_ready), 96'd0);
    end
    word_valid = 1'b0;
    w = '{16'h0102, 16'h0304, 16'h0, 16'h0, 16'h0, 16'h0};
    run_op(4, w, -1, 0, "R11 after idle words");

    // R11: start during an operation is ignored
    @(negedge clk);
    start = 1'b1; op_size = 4'd4;
    @(negedge clk);
    start = 1'b0;
    word_valid = 1'b1; word_data = 16'h1111;
    @(negedge clk);
    word_valid = 1'b0;
    start = 1'b1; op_size = 4'd12;
    @(negedge clk);
    start = 1'b0;
    chk(word_ready && !done, "R11 busy start ignored", 96'(word_ready), 96'd1);
    word_valid = 1'b1; word_data = 16'h2222;
    @(negedge clk);
    word_valid = 1'b0;
    chk(done && result == 96'h11112222 && bytes_used == 4'd4, "R11 original length kept",
        result, 96'h11112222);
    @(negedge clk);

    // random mix
    for (int t = 0; t < 60; t++) begin
      int sz = sizes[$urandom_range(0, 4)];
      int fa = -1;
      for (int i = 0; i < 6; i++) w[i] = 16'($urandom);
      if ($urandom_range(0, 5) == 0) fa = int'($urandom_range(0, 32'(exp_words(sz) - 1)));
      run_op(sz, w, fa, 1, "rand R2 R3 R4 R5 R6 R7 R9");
      if ($urandom_range(0, 7) == 0) run_op(int'($urandom_range(0, 15)), w, -1, 0, "rand R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule